// File: doc/BRIEF.md
# Fault Autoretry Sequencing Controller

This block decides what a supply manager does after a critical supply fault. While the block is enabled and monitoring, a critical-fault pulse stops monitoring at once. The 2-bit mode field then picks one of two outcomes. The block either latches off until enable is removed, or it waits a programmable retry delay and asks the boot sequencer to restart. The number of restarts can be none, one, three, or unlimited.

All delays are counted in 1 ms timebase ticks. After the boot sequencer reports that boot is complete, the block waits a further 20 ticks before monitoring resumes. A restart is never issued while the fault-store-busy flag shows that fault data is still being written to nonvolatile storage. The count of restarts used returns to zero in two cases: after one full retry-delay period of fault-free monitoring, or when enable is deasserted.

Top module: `fault_retry_ctrl`

## Requirements
- R1: A synchronous active-low reset places the block idle, with mon_en, restart_req and latched_off all low. At most one of these three outputs is high at any time.
- R2: When enable is high and store_busy is low, an idle block raises restart_req and holds it until boot_done is sampled high. Exactly 20 tick pulses after boot_done, mon_en goes high.
- R3: A crit_fault pulse sampled while mon_en is high drives mon_en low in the next cycle.
- R4: With mode cfg[4:3]=00, a fault raises latched_off and no restart follows. latched_off stays high until enable goes low. Raising enable again then starts a new restart.
- R5: After a fault that is followed by a restart, restart_req rises once exactly D tick pulses have been counted. D is set by cfg[2:0]: 000=20, 001=40, 010=80, 011=150, 100=280, 101=540, 110=1000, 111=2000.
- R6: With mode 01, one restart is allowed; with mode 10, three restarts are allowed. The next fault after the allowance is used moves the block to latched_off.
- R7: With mode 11, the block restarts after every fault and never raises latched_off.
- R8: restart_req does not rise while store_busy is high. If the retry delay has already expired, restart_req rises in the cycle after store_busy is sampled low.
- R9: If monitoring runs for D tick pulses with no fault, the used restart count returns to zero, so the full allowance is available again.
- R10: Deasserting enable drives all three outputs low in the next cycle and clears the used restart count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| crit_fault | input | 1 | Critical supply fault pulse |
| enable | input | 1 | Block enable (hardware and software enable combined) |
| store_busy | input | 1 | Fault data is being written to nonvolatile storage |
| boot_done | input | 1 | Boot sequencer has finished its boot-up delay |
| cfg | input | 5 | [4:3] mode, [2:0] retry delay code |
| mon_en | output | 1 | Threshold monitoring enabled |
| latched_off | output | 1 | Block has latched off after a fault |
| restart_req | output | 1 | Request to the boot sequencer, held until boot_done |

## Verification
The restart path is driven in endless mode once with every one of the eight delay codes. Tick counts between the fault and the restart request therefore separate any swapped or miscoded table entry. Each of the four mode encodings is then used with back-to-back faults, to separate off-by-one errors in the retry allowance. A fault-free run longer than the delay, and an enable toggle, are each followed by a fault. Together they tell a budget cleared by clean running from one cleared only by enable. Holding store_busy past the expired delay shows whether the restart waits for the store to finish. The settle interval after every boot is measured in ticks.

// File: rtl/fr_pkg.sv
// Package: shared state and mode types plus the retry-delay table.
// Assumes delays are expressed in 1 ms ticks.
package fr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BOOT   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_RUN    = 3'd3,
        ST_WAIT   = 3'd4,
        ST_LATCH  = 3'd5
    } fr_state_e;

    typedef enum logic [1:0] {
        MODE_LATCH   = 2'd0,
        MODE_ONCE    = 2'd1,
        MODE_THRICE  = 2'd2,
        MODE_ENDLESS = 2'd3
    } fr_mode_e;

    // Non-uniform retry delay table, in ticks.
    function automatic int unsigned fr_delay_ticks(input logic [2:0] code);
        case (code)
            3'd0:    return 20;
            3'd1:    return 40;
            3'd2:    return 80;
            3'd3:    return 150;
            3'd4:    return 280;
            3'd5:    return 540;
            3'd6:    return 1000;
            default: return 2000;
        endcase
    endfunction

endpackage

// File: rtl/fr_delay_sel.sv
// Module: fr_delay_sel
// Maps the 3-bit retry delay code onto a tick count.
// Assumes CNT_W is wide enough for the largest entry (2000).
module fr_delay_sel #(
    parameter int CNT_W = 12
) (
    input  logic [2:0]       code,
    output logic [CNT_W-1:0] ticks
);
    import fr_pkg::*;

    // Table lookup, purely combinational.
    always_comb begin
        ticks = CNT_W'(fr_delay_ticks(code));
    end

    // Guard: the table entry must fit in the counter.
    always_comb begin
        a_fits_r5: assert (fr_delay_ticks(code) < (2 ** CNT_W))
            else $error("delay entry exceeds counter width");
    end
endmodule

// File: rtl/fr_tick_timer.sv
// Module: fr_tick_timer
// Counts tick pulses from zero up to a target and reports done, saturating there.
// Assumes clr is asserted by the owner on every state change.
module fr_tick_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Elapsed tick counter with clear priority and saturation at target.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry compare.
    always_comb begin
        done = (cnt_q >= target);
    end

    // The count moves only on a tick or a clear.
    p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt_q));

    // The count never advances by more than one per cycle.
    p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && tick && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/fr_retry_budget.sv
// Module: fr_retry_budget
// Tracks restarts used and reports when the mode's allowance is spent.
// Assumes use_one is raised only for a fault that leads to a restart.
module fr_retry_budget #(
    parameter int BUDGET_W = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           use_one,
    input  fr_pkg::fr_mode_e mode,
    output logic           exhausted
);
    import fr_pkg::*;

    localparam logic [BUDGET_W-1:0] LIM_ONCE   = BUDGET_W'(1);
    localparam logic [BUDGET_W-1:0] LIM_THRICE = BUDGET_W'(3);
    localparam logic [BUDGET_W-1:0] SAT        = '1;

    logic [BUDGET_W-1:0] used_q;

    // Used-restart counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            used_q <= '0;
        end else if (use_one && used_q != SAT) begin
            used_q <= used_q + 1'b1;
        end
    end

    // Allowance decode per mode.
    always_comb begin
        case (mode)
            MODE_LATCH:   exhausted = 1'b1;
            MODE_ONCE:    exhausted = (used_q >= LIM_ONCE);
            MODE_THRICE:  exhausted = (used_q >= LIM_THRICE);
            default:      exhausted = 1'b0;
        endcase
    end

    // The count changes only on use or clear.
    p_budget_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !use_one) |=> $stable(used_q));

    // A restart is never granted past the allowance.
    p_budget_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (use_one && !clr && mode == MODE_ONCE) |=> (used_q <= LIM_ONCE));
endmodule

// File: rtl/fault_retry_ctrl.sv
// Module: fault_retry_ctrl (top)
// Sequences the response to a critical fault: latch off, or wait the retry delay,
// request a boot, wait a settle interval and resume monitoring.
// Assumes tick_ms is a one-cycle pulse and boot_done is sampled only during a request.
module fault_retry_ctrl #(
    parameter int CNT_W        = 12,
    parameter int SETTLE_TICKS = 20,
    parameter int BUDGET_W     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       crit_fault,
    input  logic       enable,
    input  logic       store_busy,
    input  logic       boot_done,
    input  logic [4:0] cfg,
    output logic       mon_en,
    output logic       latched_off,
    output logic       restart_req
);
    import fr_pkg::*;

    localparam logic [CNT_W-1:0] SETTLE_T = CNT_W'(SETTLE_TICKS);

    fr_state_e        state_q, state_d;
    fr_mode_e         mode;
    logic [CNT_W-1:0] delay_t, tmr_target;
    logic             tmr_clr, tmr_done;
    logic             bud_clr, bud_use, exhausted;

    // Mode field decode.
    always_comb begin
        mode = fr_mode_e'(cfg[4:3]);
    end

    fr_delay_sel #(.CNT_W(CNT_W)) u_delay (
        .code  (cfg[2:0]),
        .ticks (delay_t)
    );

    // Next-state logic: enable low overrides every state.
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:   if (!store_busy) state_d = ST_BOOT;
                ST_BOOT:   if (boot_done) state_d = ST_SETTLE;
                ST_SETTLE: if (tmr_done) state_d = ST_RUN;
                ST_RUN:    if (crit_fault) state_d = exhausted ? ST_LATCH : ST_WAIT;
                ST_WAIT:   if (tmr_done && !store_busy) state_d = ST_BOOT;
                ST_LATCH:  state_d = ST_LATCH;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Timer control: restart on every transition; settle uses its own length.
    always_comb begin
        tmr_clr    = (state_d != state_q) || (state_q == ST_IDLE) ||
                     (state_q == ST_BOOT) || (state_q == ST_LATCH);
        tmr_target = (state_q == ST_SETTLE) ? SETTLE_T : delay_t;
    end

    fr_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tick_ms),
        .target (tmr_target),
        .done   (tmr_done)
    );

    // Budget control: spend on a restarting fault, refill on clean running or disable.
    always_comb begin
        bud_use = enable && (state_q == ST_RUN) && crit_fault && !exhausted;
        bud_clr = !enable || ((state_q == ST_RUN) && tmr_done && !crit_fault);
    end

    fr_retry_budget #(.BUDGET_W(BUDGET_W)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (bud_clr),
        .use_one   (bud_use),
        .mode      (mode),
        .exhausted (exhausted)
    );

    // Output decode from state.
    always_comb begin
        mon_en      = (state_q == ST_RUN);
        restart_req = (state_q == ST_BOOT);
        latched_off = (state_q == ST_LATCH);
    end

    p_outputs_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mon_en, restart_req, latched_off}));

    p_fault_stops_mon_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && crit_fault) |=> !mon_en);

    p_latch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && enable) |=> (latched_off && !restart_req));

    p_endless_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[4:3] == 2'b11 && !latched_off) |=> !latched_off);

    p_busy_gates_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> !$past(store_busy));

    p_disable_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!mon_en && !restart_req && !latched_off));
endmodule

// File: tb/fault_retry_ctrl_tb_top.sv
`timescale 1ns/1ps
module fault_retry_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n, tick_ms, crit_fault, enable, store_busy, boot_done;
    logic [4:0] cfg;
    logic mon_en, latched_off, restart_req;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;
    int unsigned exp_q[$];

    always #10 clk = ~clk;

    fault_retry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .crit_fault(crit_fault),
        .enable(enable), .store_busy(store_busy), .boot_done(boot_done),
        .cfg(cfg), .mon_en(mon_en), .latched_off(latched_off),
        .restart_req(restart_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int unsigned exp_delay(input logic [2:0] c);
        case (c)
            3'd0: return 20;   3'd1: return 40;   3'd2: return 80;   3'd3: return 150;
            3'd4: return 280;  3'd5: return 540;  3'd6: return 1000; default: return 2000;
        endcase
    endfunction

    // Timebase: one tick every fourth cycle.
    int unsigned div = 0;
    always @(negedge clk) begin
        div <= (div == 3) ? 0 : div + 1;
        tick_ms <= (div == 3);
    end

    // Boot sequencer model: answers a request after six cycles.
    int unsigned bcnt = 0;
    always @(negedge clk) begin
        boot_done <= 1'b0;
        if (restart_req) begin
            if (bcnt == 5) begin boot_done <= 1'b1; bcnt <= 0; end
            else bcnt <= bcnt + 1;
        end else bcnt <= 0;
    end

    // Monitor: ticks from fault to restart (scoreboard) and from boot_done to mon_en.
    bit fact = 0, sact = 0;
    int unsigned fcnt = 0, scnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (crit_fault) begin fact = 1; fcnt = 0; end
            else if (fact && tick_ms) fcnt++;
            if (fact && restart_req) begin
                if (exp_q.size() > 0) begin
                    int unsigned e;
                    e = exp_q.pop_front();
                    check(fcnt == e, "R5 retry delay ticks", fcnt, e);
                end
                fact = 0;
            end
            if (!enable) fact = 0;
            if (boot_done) begin sact = 1; scnt = 0; end
            else if (sact && tick_ms) scnt++;
            if (sact && mon_en) begin
                check(scnt == 20, "R2 settle ticks", scnt, 20);
                sact = 0;
            end
            if (!enable) sact = 0;
        end
    end

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin @(negedge clk); if (tick_ms) k++; end
    endtask

    task automatic wait_mon();
        while (!mon_en) @(negedge clk);
        @(negedge clk);
    endtask

    // Driver: pushes the expected delay, then pulses the fault.
    task automatic fault(input bit expect_restart, input int unsigned ticks);
        if (expect_restart) exp_q.push_back(ticks);
        @(negedge clk); crit_fault <= 1'b1;
        @(negedge clk); crit_fault <= 1'b0;
        check(mon_en == 1'b0, "R3 monitoring stops", mon_en, 0);
    endtask

    task automatic reenable(input logic [4:0] c);
        @(negedge clk); enable <= 1'b0;
        @(negedge clk); @(negedge clk);
        check({mon_en, restart_req, latched_off} == 3'b000, "R10 disabled outputs",
              {mon_en, restart_req, latched_off}, 0);
        cfg <= c; enable <= 1'b1;
        wait_mon();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; cfg = 5'b0; crit_fault = 1'b0;
        store_busy = 1'b0; boot_done = 1'b0; tick_ms = 1'b0;
        repeat (4) @(negedge clk);
        rst_n <= 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({mon_en, restart_req, latched_off} == 3'b000, "R1 reset outputs",
              {mon_en, restart_req, latched_off}, 0);
        // R2 start-up request
        cfg <= 5'b11_000; enable <= 1'b1;
        @(negedge clk); @(negedge clk);
        check(restart_req == 1'b1, "R2 restart request", restart_req, 1);
        wait_mon();
        // R5 / R7 endless mode, every delay code
        for (int c = 0; c < 8; c++) begin
            cfg <= {2'b11, 3'(c)};
            fault(1'b1, exp_delay(3'(c)));
            wait_mon();
        end
        check(latched_off == 1'b0, "R7 endless never latches", latched_off, 0);
        // R6 one retry
        reenable(5'b01_000);
        fault(1'b1, 20); wait_mon();
        fault(1'b0, 0); @(negedge clk);
        check(latched_off == 1'b1, "R6 once then latch", latched_off, 1);
        wait_ticks(40);
        check(restart_req == 1'b0, "R6 no restart after allowance", restart_req, 0);
        // R6 three retries
        reenable(5'b10_001);
        for (int i = 0; i < 3; i++) begin fault(1'b1, 40); wait_mon(); end
        fault(1'b0, 0); @(negedge clk);
        check(latched_off == 1'b1, "R6 thrice then latch", latched_off, 1);
        // R4 latch mode
        reenable(5'b00_000);
        fault(1'b0, 0); @(negedge clk);
        check(latched_off == 1'b1, "R4 latch on fault", latched_off, 1);
        wait_ticks(50);
        check(latched_off == 1'b1 && restart_req == 1'b0, "R4 stays latched",
              {latched_off, restart_req}, 2);
        @(negedge clk); enable <= 1'b0;
        @(negedge clk); @(negedge clk);
        check(latched_off == 1'b0, "R4 release by enable", latched_off, 0);
        enable <= 1'b1;
        @(negedge clk); @(negedge clk);
        check(restart_req == 1'b1, "R4 restart after toggle", restart_req, 1);
        wait_mon();
        // R9 clean running refills the allowance
        reenable(5'b01_000);
        fault(1'b1, 20); wait_mon();
        wait_ticks(25);
        fault(1'b1, 20); @(negedge clk);
        check(latched_off == 1'b0, "R9 budget refilled", latched_off, 0);
        wait_mon();
        // R10 enable toggle clears the allowance
        reenable(5'b01_000);
        fault(1'b1, 20); wait_mon();
        reenable(5'b01_000);
        fault(1'b1, 20); @(negedge clk);
        check(latched_off == 1'b0, "R10 budget cleared", latched_off, 0);
        wait_mon();
        // R8 store busy holds the restart
        cfg <= 5'b11_000; store_busy <= 1'b1;
        fault(1'b0, 0);
        wait_ticks(40);
        check(restart_req == 1'b0, "R8 held while busy", restart_req, 0);
        store_busy <= 1'b0;
        @(negedge clk); @(negedge clk);
        check(restart_req == 1'b1, "R8 restart after busy clears", restart_req, 1);
        wait_mon();
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule